// File: doc/BRIEF.md
# Universal registered bus transceiver

This block moves data between two parallel ports, A and B, with a separate storage stage for each direction. Each direction's stage runs in one of three ways, chosen at run time by that direction's latch enable and clock: it can pass its source straight through, hold a stored word, or capture the source on a rising clock edge. The two directions have their own enable, latch-enable and clock controls, and every bit of a direction shares those controls.

Each port is modelled as three separate vectors: an input, an output and an output-enable. This avoids internal tristate nets, so the surrounding pad logic resolves the bus. The A-to-B path enables the B port with an active-high control. The B-to-A path enables the A port with an active-low control.

An optional bus-hold stage sits on each source input. When the port's "driven" flag drops, the path keeps using the last word that was sampled while the port was driven, so the path never sees a floating bus.

Top module: `ubt_xcvr`

## Requirements
- R1: While `le_ab_i` is 1 and `oe_ab_i` is 1, `b_o` equals the effective A input in the same cycle. This holds whatever `clk_ab_i` does, including across a rising edge.
- R2: While `le_ab_i` is 0 and `clk_ab_i` has no rising edge, `b_o` does not change, even when `a_i` changes.
- R3: Every rising edge of `clk_ab_i` loads the effective A input into the A-to-B stored word. This happens whether `le_ab_i` is 0 or 1. While `le_ab_i` is 0, `b_o` shows the newly loaded word right after the edge.
- R4: `b_oe_o` equals `oe_ab_i`. While `oe_ab_i` is 0, `b_o` is all zeros.
- R5: The B-to-A path works the same way, using `le_ba_i`, `clk_ba_i`, source `b_i` and destination `a_o`. `a_oe_o` is 1 exactly when `oe_ba_ni` is 0. While `oe_ba_ni` is 1, `a_o` is all zeros.
- R6: When `BUS_HOLD` is 1 and `a_drv_i` is 0, the effective A input is the `a_i` value sampled at the last rising edge of `clk_ab_i` at which `a_drv_i` was 1. `b_drv_i` does the same for `b_i`, sampled on `clk_ba_i`. When `a_drv_i` is 1, the effective A input is `a_i`. When `BUS_HOLD` is 0, the driven flags are ignored.
- R7: While `rst_ni` is 0, both stored words and both hold words are zero, and edges on `clk_ab_i` and `clk_ba_i` do not load them.
- R8: The A-to-B controls, clock and data do not change `a_o`, and the B-to-A controls, clock and data do not change `b_o`.
- R9: Suppose a rising edge of `clk_ab_i` arrives while `le_ab_i` is 1, and `le_ab_i` then falls. `b_o` then keeps the word captured at that edge, even after `a_i` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab_i | input | 1 | A-to-B capture clock, rising edge |
| clk_ba_i | input | 1 | B-to-A capture clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oe_ab_i | input | 1 | B port enable, active high |
| oe_ba_ni | input | 1 | A port enable, active low |
| le_ab_i | input | 1 | A-to-B pass-through select |
| le_ba_i | input | 1 | B-to-A pass-through select |
| a_i | input | WIDTH | Data seen on the A pins |
| a_drv_i | input | 1 | A pins are being driven externally |
| a_o | output | WIDTH | Data driven onto the A pins |
| a_oe_o | output | 1 | A pin driver enable |
| b_i | input | WIDTH | Data seen on the B pins |
| b_drv_i | input | 1 | B pins are being driven externally |
| b_o | output | WIDTH | Data driven onto the B pins |
| b_oe_o | output | 1 | B pin driver enable |

## Verification
A wrong stored word cannot be seen while its direction is in pass-through. It appears on the destination output as soon as the latch enable drops with the driver enabled, and then stays visible until the next rising edge of that direction's clock. A wrong hold word shows up only when the driven flag is low. It then appears at once in pass-through, or one edge later through the stored word. For this reason the bench sweeps many data words through every mode transition and every order of the driven flag. It compares both outputs and both enables after every single stimulus.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
  localparam int unsigned UBT_WIDTH = 18;

  typedef struct packed {
    logic le;  // pass-through select
    logic oe;  // driver enable, active high after polarity fix
  } path_ctrl_t;
endpackage

// File: rtl/ubt_bus_hold.sv
module ubt_bus_hold #(
  parameter int unsigned WIDTH   = 18,
  parameter bit          ENABLE  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din_i,
  input  logic             drv_i,
  output logic [WIDTH-1:0] dout_o
);
  generate
    if (ENABLE) begin : g_hold
      logic [WIDTH-1:0] held_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    held_q <= '0;
        else if (drv_i) held_q <= din_i;
      end
      assign dout_o = drv_i ? din_i : held_q;
    end else begin : g_pass
      logic unused_drv;
      assign unused_drv = drv_i;
      assign dout_o     = din_i;
    end
  endgenerate
endmodule

// File: rtl/ubt_path.sv
module ubt_path
  import ubt_pkg::*;
#(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  path_ctrl_t       ctrl_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             oe_o
);
  logic [WIDTH-1:0] store_q;
  logic [WIDTH-1:0] sel;

  // loads on every edge, so the word stays continuous when le falls
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) store_q <= '0;
    else         store_q <= din_i;
  end

  assign sel    = ctrl_i.le ? din_i : store_q;
  assign dout_o = ctrl_i.oe ? sel : '0;
  assign oe_o   = ctrl_i.oe;
endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr
  import ubt_pkg::*;
#(
  parameter int unsigned WIDTH    = UBT_WIDTH,
  parameter bit          BUS_HOLD = 1'b1
) (
  input  logic             clk_ab_i,
  input  logic             clk_ba_i,
  input  logic             rst_ni,
  input  logic             oe_ab_i,
  input  logic             oe_ba_ni,
  input  logic             le_ab_i,
  input  logic             le_ba_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic             a_drv_i,
  output logic [WIDTH-1:0] a_o,
  output logic             a_oe_o,
  input  logic [WIDTH-1:0] b_i,
  input  logic             b_drv_i,
  output logic [WIDTH-1:0] b_o,
  output logic             b_oe_o
);
  logic [WIDTH-1:0] a_eff, b_eff;
  path_ctrl_t       ctrl_ab, ctrl_ba;

  assign ctrl_ab = '{le: le_ab_i, oe: oe_ab_i};
  assign ctrl_ba = '{le: le_ba_i, oe: ~oe_ba_ni};

  ubt_bus_hold #(.WIDTH(WIDTH), .ENABLE(BUS_HOLD)) u_hold_a (
    .clk_i (clk_ab_i), .rst_ni (rst_ni),
    .din_i (a_i), .drv_i (a_drv_i), .dout_o (a_eff)
  );

  ubt_bus_hold #(.WIDTH(WIDTH), .ENABLE(BUS_HOLD)) u_hold_b (
    .clk_i (clk_ba_i), .rst_ni (rst_ni),
    .din_i (b_i), .drv_i (b_drv_i), .dout_o (b_eff)
  );

  ubt_path #(.WIDTH(WIDTH)) u_path_ab (
    .clk_i (clk_ab_i), .rst_ni (rst_ni), .ctrl_i (ctrl_ab),
    .din_i (a_eff), .dout_o (b_o), .oe_o (b_oe_o)
  );

  ubt_path #(.WIDTH(WIDTH)) u_path_ba (
    .clk_i (clk_ba_i), .rst_ni (rst_ni), .ctrl_i (ctrl_ba),
    .din_i (b_eff), .dout_o (a_o), .oe_o (a_oe_o)
  );
endmodule

// File: rtl/ubt_xcvr_chk.sv
module ubt_xcvr_chk #(
  parameter int unsigned WIDTH    = 18,
  parameter bit          BUS_HOLD = 1'b1
) (
  input logic             clk_ab_i,
  input logic             clk_ba_i,
  input logic             rst_ni,
  input logic             oe_ab_i,
  input logic             oe_ba_ni,
  input logic             le_ab_i,
  input logic             le_ba_i,
  input logic [WIDTH-1:0] a_i,
  input logic             a_drv_i,
  input logic [WIDTH-1:0] a_o,
  input logic             a_oe_o,
  input logic [WIDTH-1:0] b_i,
  input logic             b_drv_i,
  input logic [WIDTH-1:0] b_o,
  input logic             b_oe_o
);
  a_r1_pass_through: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    le_ab_i && oe_ab_i && (a_drv_i || !BUS_HOLD) |-> b_o == a_i);

  a_r3_edge_capture: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    $past(rst_ni) && !le_ab_i && oe_ab_i && (!BUS_HOLD || $past(a_drv_i))
    |-> b_o == $past(a_i));

  a_r4_b_disabled: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    !oe_ab_i |-> b_o == '0 && !b_oe_o);

  a_r5_ba_capture: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    $past(rst_ni) && !le_ba_i && !oe_ba_ni && (!BUS_HOLD || $past(b_drv_i))
    |-> a_o == $past(b_i));

  a_r5_a_disabled: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    oe_ba_ni |-> a_o == '0 && !a_oe_o);

  generate
    if (BUS_HOLD) begin : g_hold_chk
      a_r6_hold_a: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
        $past(rst_ni) && $past(a_drv_i) && !a_drv_i && le_ab_i && oe_ab_i
        |-> b_o == $past(a_i));
      a_r6_hold_b: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
        $past(rst_ni) && $past(b_drv_i) && !b_drv_i && le_ba_i && !oe_ba_ni
        |-> a_o == $past(b_i));
    end
  endgenerate
endmodule

bind ubt_xcvr ubt_xcvr_chk #(.WIDTH(WIDTH), .BUS_HOLD(BUS_HOLD)) u_chk (
  .clk_ab_i (clk_ab_i), .clk_ba_i (clk_ba_i), .rst_ni (rst_ni),
  .oe_ab_i (oe_ab_i), .oe_ba_ni (oe_ba_ni), .le_ab_i (le_ab_i), .le_ba_i (le_ba_i),
  .a_i (a_i), .a_drv_i (a_drv_i), .a_o (a_o), .a_oe_o (a_oe_o),
  .b_i (b_i), .b_drv_i (b_drv_i), .b_o (b_o), .b_oe_o (b_oe_o)
);

// File: tb/tb_ubt_xcvr.sv
`timescale 1ns/1ps
module tb_ubt_xcvr;
  localparam int unsigned W = 18;
  localparam logic [W-1:0] MASK = '1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;  // 200 MHz

  logic clk_ab_i = 0, clk_ba_i = 0, rst_ni = 0;
  logic oe_ab_i = 0, oe_ba_ni = 1, le_ab_i = 0, le_ba_i = 0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic a_drv_i = 1, b_drv_i = 1;
  logic [W-1:0] a_o, b_o;
  logic a_oe_o, b_oe_o;

  ubt_xcvr #(.WIDTH(W), .BUS_HOLD(1'b1)) dut (.*);

  int n_run = 0, n_fail = 0, cyc = 0;
  logic [W-1:0] st_ab = '0, st_ba = '0, hold_a = '0, hold_b = '0;

  function automatic logic [W-1:0] eff_a();
    return a_drv_i ? a_i : hold_a;
  endfunction
  function automatic logic [W-1:0] eff_b();
    return b_drv_i ? b_i : hold_b;
  endfunction

  task automatic cmp(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk(string tag);
    logic [W-1:0] eb, ea;
    #1;
    eb = oe_ab_i ? (le_ab_i ? eff_a() : st_ab) : '0;
    ea = !oe_ba_ni ? (le_ba_i ? eff_b() : st_ba) : '0;
    cmp(tag, "b_o", b_o, eb);
    cmp(tag, "a_o", a_o, ea);
    cmp(tag, "b_oe_o", {{(W-1){1'b0}}, b_oe_o}, {{(W-1){1'b0}}, oe_ab_i});
    cmp(tag, "a_oe_o", {{(W-1){1'b0}}, a_oe_o}, {{(W-1){1'b0}}, !oe_ba_ni});
  endtask

  task automatic pulse_ab();
    if (rst_ni) begin
      st_ab = eff_a();
      if (a_drv_i) hold_a = a_i;
    end
    #1 clk_ab_i = 1; #2 clk_ab_i = 0; #1;
  endtask

  task automatic pulse_ba();
    if (rst_ni) begin
      st_ba = eff_b();
      if (b_drv_i) hold_b = b_i;
    end
    #1 clk_ba_i = 1; #2 clk_ba_i = 0; #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pa, pb;
    #7;
    oe_ab_i = 1; oe_ba_ni = 0;
    a_i = 18'h2A5C3; b_i = 18'h15A3C;
    chk("R7 reset state");
    pulse_ab(); pulse_ba();
    chk("R7 edges in reset");
    #3 rst_ni = 1; #3;
    chk("R7 after release");

    for (int k = 0; k < 24; k++) begin
      pa = W'((k * 193057 + 5) & MASK);
      pb = W'((~pa ^ W'(k << 3)) & MASK);
      // A to B
      le_ab_i = 1; oe_ab_i = 1; a_i = pa;
      chk("R1 pass-through");
      pulse_ab();
      chk("R1 edge during pass-through");
      le_ab_i = 0;
      chk("R9 le fall keeps edge word");
      a_i = pa ^ MASK;
      chk("R2 hold ignores a_i");
      chk("R8 a_o unaffected by A-to-B");
      pulse_ab();
      chk("R3 capture on edge");
      oe_ab_i = 0;
      chk("R4 B disabled");
      oe_ab_i = 1;
      // B to A
      le_ba_i = 1; oe_ba_ni = 0; b_i = pb;
      chk("R5 pass-through");
      pulse_ba();
      le_ba_i = 0; b_i = pb ^ W'(k + 1);
      chk("R5 hold");
      chk("R8 b_o unaffected by B-to-A");
      pulse_ba();
      chk("R5 capture");
      oe_ba_ni = 1;
      chk("R5 A disabled");
      oe_ba_ni = 0;
      // bus hold on A
      le_ab_i = 1; a_i = pb; a_drv_i = 1;
      pulse_ab();
      a_drv_i = 0; a_i = pa;
      chk("R6 A held in pass-through");
      pulse_ab();
      le_ab_i = 0;
      chk("R6 A held through edge");
      a_drv_i = 1;
      // bus hold on B
      le_ba_i = 1; b_i = pa; b_drv_i = 1;
      pulse_ba();
      b_drv_i = 0; b_i = pb;
      chk("R6 B held in pass-through");
      pulse_ba();
      le_ba_i = 0;
      chk("R6 B held through edge");
      b_drv_i = 1;
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule